// File: doc/BRIEF.md
# Indexed Postbyte Effective Address Unit

This unit turns the postbyte of an indexed-mode instruction into a 16-bit effective address. The postbyte is one packed byte. It selects the base register, either a short signed offset or an extended mode code, and optionally one level of indirection. The caller presents the postbyte, the two bytes that follow it in the instruction stream, and the current contents of the X, Y, U and S registers, the accumulators A and B (D is their concatenation, A high), and the address of the byte after the postbyte. It pulses `start`, and some cycles later it receives a one-cycle `done` pulse with these results:
- the address;
- how many of the following bytes the instruction uses;
- for post-increment and pre-decrement forms, a write-back request for the base register.

When an indirect form is selected, the computed address points at a 16-bit pointer. The unit fetches it through a synchronous byte-read port (read data appears one cycle after the request) and returns the pointer as the final address. Instruction fetch, opcode decoding and the data access itself belong to the caller.

Top module: `idx_ea_unit`

## Requirements
- R1: Postbyte bits 6:5 choose the base register for every non-PC form. The codes are 00 for X, 01 for Y, 10 for U and 11 for S.
- R2: With postbyte bit 7 clear, bits 4:0 are a signed offset in the range -16..+15, added to the base. Zero extension bytes are used (e.g. 0x25 gives Y+5).
- R3: With bit 7 set, the mode code in bits 3:0 is read as follows:
  - 0100 adds nothing and uses 0 extension bytes.
  - 1000 adds the first extension byte, sign-extended, and uses 1 extension byte.
  - 1001 adds the 16-bit value {first, second} (first byte high) and uses 2 extension bytes.
- R4: Codes 0000 and 0001 use the unchanged base as the address. They request write-back (`wb_en`=1, `wb_sel`=bits 6:5) of the base plus 1 or plus 2.
- R5: Codes 0010 and 0011 request write-back of the base minus 1 or minus 2, and use that decremented value as the address.
- R6: Code 0110 adds signed A to the base, code 0101 adds signed B, and code 1011 adds D={A,B}.
- R7: Codes 1100 and 1101 use 1 or 2 extension bytes and add an 8-bit signed or 16-bit offset. Their base is `pc_next` plus the number of extension bytes used, and bits 6:5 have no effect.
- R8: With bit 7 and bit 4 both set, the computed address P is a pointer location. The unit reads the byte at P and then the byte at P+1, and returns {byte at P, byte at P+1} as the address. `done` comes 4 cycles after the accepted start instead of 1.
- R9: The following codes are illegal: 0111, 1010, 1110 and 1111, plus 0000 or 0010 with bit 4 set. An illegal code gives `illegal`=1, `ea`=0, `ext_used`=0 and `wb_en`=0, and starts no memory read.
- R10: A start accepted while idle gives a one-cycle `done` pulse 1 cycle later for non-indirect forms. `wb_en` is only ever high together with `done`. A `start` while `busy` is ignored.
- R11: All address sums and differences wrap modulo 2^16.
- R12: After reset, `done`, `busy`, `wb_en`, `illegal` and `mem_rd_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to compute an address; accepted when not busy |
| postbyte | input | 8 | Indexed postbyte |
| ext_b0 | input | 8 | First byte after the postbyte |
| ext_b1 | input | 8 | Second byte after the postbyte |
| reg_x | input | 16 | X register |
| reg_y | input | 16 | Y register |
| reg_u | input | 16 | U register |
| reg_s | input | 16 | S register |
| pc_next | input | 16 | Address of the byte after the postbyte |
| acc_a | input | 8 | Accumulator A (high half of D) |
| acc_b | input | 8 | Accumulator B (low half of D) |
| mem_rd_en | output | 1 | Pointer byte read request |
| mem_addr | output | 16 | Pointer byte read address |
| mem_rdata | input | 8 | Read data, valid the cycle after the request |
| busy | output | 1 | Indirect pointer fetch in progress |
| done | output | 1 | One-cycle result strobe |
| ea | output | 16 | Effective address, held until the next result |
| ext_used | output | 2 | Extension bytes used (0, 1 or 2) |
| wb_en | output | 1 | Base register write-back request |
| wb_sel | output | 2 | Register to write back (bits 6:5 code) |
| wb_value | output | 16 | Value to write back |
| illegal | output | 1 | Unassigned mode code seen |

## Verification
The bench builds the unit with the default `PTR_HI_FIRST`=1, so pointers are assembled with the byte at the lower address as the high half. This brings the R8 byte order and the two-read sequence within reach of the checks. The register values are random across the full 16-bit range, so carries, borrows and wrap-around past 0xFFFF and 0x0000 arise in the base, offset, PC-relative and write-back paths. The bench model reads from a memory whose contents are a function of the address, so a swapped or misaddressed pointer byte changes the returned address.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;

  localparam int ADDR_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int SHORT_W = 5;
  localparam int CNT_W   = 2;

  typedef enum logic [3:0] {
    M_OFS5, M_NONE, M_OFS8, M_OFS16,
    M_ACC_A, M_ACC_B, M_ACC_D,
    M_PC8, M_PC16,
    M_INC1, M_INC2, M_DEC1, M_DEC2,
    M_ILL
  } idx_mode_e;

  typedef struct packed {
    idx_mode_e        mode;
    logic             indirect;
    logic [1:0]       rsel;
    logic [CNT_W-1:0] ext_cnt;
  } idx_dec_t;

  function automatic logic [ADDR_W-1:0] sx_short(input logic [SHORT_W-1:0] v);
    return {{(ADDR_W-SHORT_W){v[SHORT_W-1]}}, v};
  endfunction

  function automatic logic [ADDR_W-1:0] sx_byte(input logic [BYTE_W-1:0] v);
    return {{(ADDR_W-BYTE_W){v[BYTE_W-1]}}, v};
  endfunction

  function automatic logic [ADDR_W-1:0] step_of(input idx_mode_e m);
    return (m == M_INC2 || m == M_DEC2) ? ADDR_W'(2) : ADDR_W'(1);
  endfunction

  function automatic logic is_inc(input idx_mode_e m);
    return (m == M_INC1) || (m == M_INC2);
  endfunction

  function automatic logic is_dec(input idx_mode_e m);
    return (m == M_DEC1) || (m == M_DEC2);
  endfunction

endpackage

// File: rtl/idx_mode_decode.sv
module idx_mode_decode
  import idx_ea_pkg::*;
(
  input  logic [7:0] postbyte,
  output idx_dec_t   dec
);

  logic       ext_form;
  logic [3:0] code_lo;

  assign ext_form = postbyte[7];
  assign code_lo  = postbyte[3:0];

  always_comb begin
    dec.rsel     = postbyte[6:5];
    dec.indirect = 1'b0;
    dec.mode     = M_OFS5;
    if (ext_form) begin
      dec.indirect = postbyte[4];
      case (code_lo)
        4'h0:    dec.mode = M_INC1;
        4'h1:    dec.mode = M_INC2;
        4'h2:    dec.mode = M_DEC1;
        4'h3:    dec.mode = M_DEC2;
        4'h4:    dec.mode = M_NONE;
        4'h5:    dec.mode = M_ACC_B;
        4'h6:    dec.mode = M_ACC_A;
        4'h8:    dec.mode = M_OFS8;
        4'h9:    dec.mode = M_OFS16;
        4'hB:    dec.mode = M_ACC_D;
        4'hC:    dec.mode = M_PC8;
        4'hD:    dec.mode = M_PC16;
        default: dec.mode = M_ILL;
      endcase
      // single-step auto forms have no indirect variant
      if (postbyte[4] && (dec.mode == M_INC1 || dec.mode == M_DEC1))
        dec.mode = M_ILL;
      if (dec.mode == M_ILL)
        dec.indirect = 1'b0;
    end
    case (dec.mode)
      M_OFS8, M_PC8:   dec.ext_cnt = CNT_W'(1);
      M_OFS16, M_PC16: dec.ext_cnt = CNT_W'(2);
      default:         dec.ext_cnt = '0;
    endcase
  end

endmodule

// File: rtl/idx_addr_calc.sv
module idx_addr_calc
  import idx_ea_pkg::*;
(
  input  idx_dec_t            dec,
  input  logic [SHORT_W-1:0]  short_ofs,
  input  logic [BYTE_W-1:0]   ext_b0,
  input  logic [BYTE_W-1:0]   ext_b1,
  input  logic [ADDR_W-1:0]   reg_x,
  input  logic [ADDR_W-1:0]   reg_y,
  input  logic [ADDR_W-1:0]   reg_u,
  input  logic [ADDR_W-1:0]   reg_s,
  input  logic [ADDR_W-1:0]   pc_next,
  input  logic [BYTE_W-1:0]   acc_a,
  input  logic [BYTE_W-1:0]   acc_b,
  output logic [ADDR_W-1:0]   ea,
  output logic                wb_en,
  output logic [ADDR_W-1:0]   wb_val
);

  logic [ADDR_W-1:0] pc_eff, base_reg, base, offset, step;
  logic              pc_form;

  assign pc_form = (dec.mode == M_PC8) || (dec.mode == M_PC16);
  assign pc_eff  = pc_next + {{(ADDR_W-CNT_W){1'b0}}, dec.ext_cnt};
  assign step    = step_of(dec.mode);

  always_comb begin
    case (dec.rsel)
      2'd0:    base_reg = reg_x;
      2'd1:    base_reg = reg_y;
      2'd2:    base_reg = reg_u;
      default: base_reg = reg_s;
    endcase
  end

  assign base = pc_form ? pc_eff : base_reg;

  always_comb begin
    case (dec.mode)
      M_OFS5:          offset = sx_short(short_ofs);
      M_OFS8, M_PC8:   offset = sx_byte(ext_b0);
      M_OFS16, M_PC16: offset = {ext_b0, ext_b1};
      M_ACC_A:         offset = sx_byte(acc_a);
      M_ACC_B:         offset = sx_byte(acc_b);
      M_ACC_D:         offset = {acc_a, acc_b};
      default:         offset = '0;
    endcase
  end

  always_comb begin
    wb_en  = 1'b0;
    wb_val = base;
    ea     = base + offset;
    if (is_inc(dec.mode)) begin
      wb_en  = 1'b1;
      wb_val = base + step;
      ea     = base;
    end else if (is_dec(dec.mode)) begin
      wb_en  = 1'b1;
      wb_val = base - step;
      ea     = base - step;
    end else if (dec.mode == M_ILL) begin
      ea     = '0;
      wb_val = '0;
    end
  end

endmodule

// File: rtl/idx_ptr_fetch.sv
module idx_ptr_fetch
  import idx_ea_pkg::*;
#(
  parameter bit PTR_HI_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [ADDR_W-1:0] ptr_addr,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              busy,
  output logic              fin,
  output logic [ADDR_W-1:0] ptr_val
);

  typedef enum logic [1:0] {F_IDLE, F_RD_A, F_RD_B, F_WAIT_B} fst_e;

  fst_e              st;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] first_q;
  logic              rd_second;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= F_IDLE;
      addr_q  <= '0;
      first_q <= '0;
    end else begin
      case (st)
        F_IDLE: if (launch) begin
          addr_q <= ptr_addr;
          st     <= F_RD_A;
        end
        F_RD_A: st <= F_RD_B;
        F_RD_B: begin
          first_q <= mem_rdata;
          st      <= F_WAIT_B;
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  assign rd_second = (st == F_RD_B);
  assign mem_rd_en = (st == F_RD_A) || rd_second;
  assign mem_addr  = rd_second ? addr_q + ADDR_W'(1) : addr_q;
  assign busy      = (st != F_IDLE);
  assign fin       = (st == F_WAIT_B);

  generate
    if (PTR_HI_FIRST) begin : g_hi_first
      assign ptr_val = {first_q, mem_rdata};
    end else begin : g_lo_first
      assign ptr_val = {mem_rdata, first_q};
    end
  endgenerate

  // R8: second pointer byte comes from the next address
  a_r8_second_addr: assert property (@(posedge clk) disable iff (!rst_n)
    rd_second |-> mem_addr == $past(mem_addr) + ADDR_W'(1));
  // R8: a launch issues a read in the next cycle
  a_r8_launch_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !busy) |=> mem_rd_en);
  // R8: result only after a read
  a_r8_fin_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> $past(mem_rd_en));

endmodule

// File: rtl/idx_ea_unit.sv
module idx_ea_unit
  import idx_ea_pkg::*;
#(
  parameter bit PTR_HI_FIRST = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  postbyte,
  input  logic [7:0]  ext_b0,
  input  logic [7:0]  ext_b1,
  input  logic [15:0] reg_x,
  input  logic [15:0] reg_y,
  input  logic [15:0] reg_u,
  input  logic [15:0] reg_s,
  input  logic [15:0] pc_next,
  input  logic [7:0]  acc_a,
  input  logic [7:0]  acc_b,
  output logic        mem_rd_en,
  output logic [15:0] mem_addr,
  input  logic [7:0]  mem_rdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] ea,
  output logic [1:0]  ext_used,
  output logic        wb_en,
  output logic [1:0]  wb_sel,
  output logic [15:0] wb_value,
  output logic        illegal
);

  idx_dec_t          dec;
  logic [ADDR_W-1:0] calc_ea, calc_wb_val, ptr_val;
  logic              calc_wb_en, accept, launch, fin;

  logic              done_q, wb_en_q, illegal_q, pend_wb_q, ind_q, inc_q, dec_q;
  logic [ADDR_W-1:0] ea_q, wb_val_q;
  logic [1:0]        wb_sel_q;
  logic [CNT_W-1:0]  ext_q;

  idx_mode_decode u_dec (
    .postbyte (postbyte),
    .dec      (dec)
  );

  idx_addr_calc u_calc (
    .dec       (dec),
    .short_ofs (postbyte[4:0]),
    .ext_b0    (ext_b0),
    .ext_b1    (ext_b1),
    .reg_x     (reg_x),
    .reg_y     (reg_y),
    .reg_u     (reg_u),
    .reg_s     (reg_s),
    .pc_next   (pc_next),
    .acc_a     (acc_a),
    .acc_b     (acc_b),
    .ea        (calc_ea),
    .wb_en     (calc_wb_en),
    .wb_val    (calc_wb_val)
  );

  assign accept = start && !busy;
  assign launch = accept && dec.indirect;

  idx_ptr_fetch #(.PTR_HI_FIRST(PTR_HI_FIRST)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .ptr_addr  (calc_ea),
    .mem_rd_en (mem_rd_en),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .busy      (busy),
    .fin       (fin),
    .ptr_val   (ptr_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q    <= 1'b0;
      wb_en_q   <= 1'b0;
      illegal_q <= 1'b0;
      pend_wb_q <= 1'b0;
      ind_q     <= 1'b0;
      inc_q     <= 1'b0;
      dec_q     <= 1'b0;
      ea_q      <= '0;
      wb_val_q  <= '0;
      wb_sel_q  <= '0;
      ext_q     <= '0;
    end else begin
      done_q  <= 1'b0;
      wb_en_q <= 1'b0;
      if (accept) begin
        ext_q     <= dec.ext_cnt;
        illegal_q <= (dec.mode == M_ILL);
        wb_sel_q  <= dec.rsel;
        wb_val_q  <= calc_wb_val;
        pend_wb_q <= calc_wb_en;
        ind_q     <= dec.indirect;
        inc_q     <= is_inc(dec.mode);
        dec_q     <= is_dec(dec.mode);
        if (!dec.indirect) begin
          done_q  <= 1'b1;
          ea_q    <= calc_ea;
          wb_en_q <= calc_wb_en;
        end
      end
      if (fin) begin
        done_q  <= 1'b1;
        ea_q    <= ptr_val;
        wb_en_q <= pend_wb_q;
      end
    end
  end

  assign done     = done_q;
  assign ea       = ea_q;
  assign ext_used = ext_q;
  assign wb_en    = wb_en_q;
  assign wb_sel   = wb_sel_q;
  assign wb_value = wb_val_q;
  assign illegal  = illegal_q;

  // R10: direct forms finish one cycle after acceptance
  a_r10_direct_done: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !launch) |=> done);
  // R10: write-back only with the result strobe
  a_r10_wb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done);
  // R10: start while busy leaves the captured results alone
  a_r10_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(ext_used) && $stable(illegal) && $stable(wb_sel)));
  // R9: illegal code requests nothing
  a_r9_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!wb_en && ext_used == 2'd0 && !busy));
  // R5: pre-decrement address equals written-back value
  a_r5_dec_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wb_en && dec_q && !ind_q) |-> ea == wb_value);
  // R4: post-increment address is one or two below write-back value
  a_r4_inc_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wb_en && inc_q && !ind_q) |->
      ((wb_value - ea) == 16'd1 || (wb_value - ea) == 16'd2));

endmodule

// File: tb/idx_ea_unit_bench.sv
module idx_ea_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  pb = '0, e0 = '0, e1 = '0, a_r = '0, b_r = '0;
  logic [15:0] x_r = '0, y_r = '0, u_r = '0, s_r = '0, pc_r = '0;
  logic        mem_rd_en, busy, done, wb_en, illegal;
  logic [15:0] mem_addr, ea, wb_value;
  logic [7:0]  mem_rdata = '0;
  logic [1:0]  ext_used, wb_sel;

  int checks = 0, fails = 0, reads = 0, cyc = 0;

  logic [15:0] exp_ea, exp_wbv;
  int          exp_ext, exp_lat, exp_reads;
  bit          exp_wb, exp_ill;
  string       exp_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_ea_unit u_idx_ea_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .postbyte(pb),
    .ext_b0(e0), .ext_b1(e1), .reg_x(x_r), .reg_y(y_r), .reg_u(u_r),
    .reg_s(s_r), .pc_next(pc_r), .acc_a(a_r), .acc_b(b_r),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .ea(ea), .ext_used(ext_used),
    .wb_en(wb_en), .wb_sel(wb_sel), .wb_value(wb_value), .illegal(illegal)
  );

  function automatic logic [7:0] memb(input logic [15:0] ad);
    return ad[7:0] ^ {ad[11:8], ad[15:12]} ^ 8'hA7;
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rdata <= memb(mem_addr);
      reads++;
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      checks++; fails++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      finish_run();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int sgn8(input logic [7:0] v);
    return v[7] ? int'(v) - 256 : int'(v);
  endfunction

  function automatic void predict();
    int base, ofs;
    bit ind;
    logic [15:0] p;
    case (pb[6:5])
      2'd0: base = int'(x_r);
      2'd1: base = int'(y_r);
      2'd2: base = int'(u_r);
      default: base = int'(s_r);
    endcase
    exp_wb = 0; exp_ill = 0; exp_ext = 0; exp_wbv = '0; ind = 0; ofs = 0;
    if (!pb[7]) begin
      exp_tag = "R2";
      ofs = pb[4] ? int'(pb[4:0]) - 32 : int'(pb[4:0]);
      exp_ea = 16'(base + ofs);
    end else begin
      ind = pb[4];
      case (pb[3:0])
        4'h0, 4'h1: begin
          exp_tag = "R4"; exp_wb = 1; exp_ea = 16'(base);
          exp_wbv = 16'(base + (pb[0] ? 2 : 1));
          if (ind && !pb[0]) exp_ill = 1;
        end
        4'h2, 4'h3: begin
          exp_tag = "R5"; exp_wb = 1;
          exp_wbv = 16'(base - (pb[0] ? 2 : 1)); exp_ea = exp_wbv;
          if (ind && !pb[0]) exp_ill = 1;
        end
        4'h4: begin exp_tag = "R3"; exp_ea = 16'(base); end
        4'h5: begin exp_tag = "R6"; exp_ea = 16'(base + sgn8(b_r)); end
        4'h6: begin exp_tag = "R6"; exp_ea = 16'(base + sgn8(a_r)); end
        4'hB: begin exp_tag = "R6"; exp_ea = 16'(base + int'({a_r, b_r})); end
        4'h8: begin exp_tag = "R3"; exp_ext = 1; exp_ea = 16'(base + sgn8(e0)); end
        4'h9: begin exp_tag = "R3"; exp_ext = 2; exp_ea = 16'(base + int'({e0, e1})); end
        4'hC: begin exp_tag = "R7"; exp_ext = 1; exp_ea = 16'(int'(pc_r) + 1 + sgn8(e0)); end
        4'hD: begin exp_tag = "R7"; exp_ext = 2; exp_ea = 16'(int'(pc_r) + 2 + int'({e0, e1})); end
        default: exp_ill = 1;
      endcase
    end
    if (exp_ill) begin
      exp_tag = "R9"; exp_ea = '0; exp_ext = 0; exp_wb = 0; ind = 0;
    end
    exp_lat = 1; exp_reads = 0;
    if (ind) begin
      p = exp_ea;
      exp_ea = {memb(p), memb(16'(p + 16'd1))};
      exp_tag = {exp_tag, "/R8"};
      exp_lat = 4; exp_reads = 2;
    end
  endfunction

  task automatic run_case(input string tag_over);
    int lat, r0;
    string t;
    predict();
    t = (tag_over != "") ? tag_over : exp_tag;
    r0 = reads;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    chk({t, " R10 latency"}, 32'(lat), 32'(exp_lat));
    chk({t, " ea"}, {16'h0, ea}, {16'h0, exp_ea});
    chk({t, " ext_used"}, {30'h0, ext_used}, 32'(exp_ext));
    chk({t, " wb_en"}, {31'h0, wb_en}, {31'h0, exp_wb});
    if (exp_wb) begin
      chk({t, " wb_sel R1"}, {30'h0, wb_sel}, {30'h0, pb[6:5]});
      chk({t, " wb_value"}, {16'h0, wb_value}, {16'h0, exp_wbv});
    end
    chk({t, " illegal"}, {31'h0, illegal}, {31'h0, exp_ill});
    chk({t, " reads"}, 32'(reads - r0), 32'(exp_reads));
    @(negedge clk);
    chk({t, " R10 done pulse"}, {31'h0, done}, 32'h0);
  endtask

  task automatic rand_regs();
    x_r = 16'($urandom); y_r = 16'($urandom); u_r = 16'($urandom);
    s_r = 16'($urandom); pc_r = 16'($urandom);
    a_r = 8'($urandom); b_r = 8'($urandom);
    e0 = 8'($urandom); e1 = 8'($urandom);
  endtask

  initial begin
    void'($urandom(32'h1D5EA));
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 done", {31'h0, done}, 32'h0);
    chk("R12 busy", {31'h0, busy}, 32'h0);
    chk("R12 wb_en", {31'h0, wb_en}, 32'h0);
    chk("R12 illegal", {31'h0, illegal}, 32'h0);
    chk("R12 mem_rd_en", {31'h0, mem_rd_en}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    x_r = 16'h1000; y_r = 16'h2000; u_r = 16'h3000; s_r = 16'h4000;
    pc_r = 16'h8000; a_r = 8'hF0; b_r = 8'h7F; e0 = 8'h80; e1 = 8'h01;
    // R1: each base register through the short form
    for (int r = 0; r < 4; r++) begin
      pb = {1'b0, 2'(r), 5'h03};
      run_case("R1");
    end
    pb = 8'h25; run_case("R2");               // Y+5
    pb = 8'h10; run_case("R2");               // X-16
    pb = 8'h84; run_case("R3");
    pb = 8'hA8; run_case("R3");               // Y + (-128)
    pb = 8'hC9; run_case("R3");               // U + 0x8001
    pb = 8'h80; run_case("R4");
    pb = 8'hE1; run_case("R4");
    pb = 8'h82; run_case("R5");
    pb = 8'hA3; run_case("R5");
    pb = 8'h86; run_case("R6");
    pb = 8'h85; run_case("R6");
    pb = 8'h8B; run_case("R6");
    pb = 8'h8C; run_case("R7");
    pb = 8'hEC; run_case("R7");               // register bits differ, same result
    pb = 8'hCD; run_case("R7");
    pb = 8'h94; run_case("R8");
    pb = 8'hB9; run_case("R8");
    pb = 8'hD1; run_case("R8");
    pb = 8'h87; run_case("R9");
    pb = 8'h8E; run_case("R9");
    pb = 8'h90; run_case("R9");
    pb = 8'hB2; run_case("R9");
    // R11: wrap both ways
    x_r = 16'hFFFF; pb = 8'h81; run_case("R11");
    x_r = 16'h0000; pb = 8'h83; run_case("R11");
    y_r = 16'hFFF8; pb = 8'h2F; run_case("R11");

    // R10: start while busy is ignored
    x_r = 16'h1234; pb = 8'h94;
    predict();
    begin
      logic [15:0] keep_ea;
      int lat;
      keep_ea = exp_ea;
      start = 1'b1; @(negedge clk);
      pb = 8'h25; @(negedge clk);
      start = 1'b0;
      lat = 2;
      while (!done && lat < 10) begin @(negedge clk); lat++; end
      chk("R10 busy start ignored ea", {16'h0, ea}, {16'h0, keep_ea});
      chk("R10 busy start latency", 32'(lat), 32'd4);
      @(negedge clk);
      chk("R10 no extra done", {31'h0, done}, 32'h0);
      @(negedge clk);
      chk("R10 no extra done 2", {31'h0, done}, 32'h0);
    end

    for (int i = 0; i < 400; i++) begin
      rand_regs();
      pb = 8'($urandom);
      run_case("");
    end
    finish_run();
  end

endmodule